// File: doc/BRIEF.md
# Fetch Stage Status Controller

This block is the control state machine of a single-thread instruction fetch stage. It keeps the fetch PC and asks the instruction cache for the aligned line that holds it. On a miss it waits for a tagged completion. From the valid line it strobes up to a fixed number of 32-bit instruction slots per cycle. Each slot describes one instruction: its destination count, whether it is predicted taken, whether it serializes before or after itself, and whether it is a quiesce.

The controller keeps a pool of rename credits. Each strobed slot uses credits for its destinations, and the back end returns credits. Strobing halts when one of these occurs: the instruction buffer has no room, the PC leaves the line, a taken prediction, the credit pool runs out, a serializing instruction, a quiesce, a fetch fault, or a blocked back end. Each halt leaves the controller in a status that a neighbour stage can read. A squash from the back end overrides everything and redirects the PC. The cache, the branch predictor and decode are outside this block. Predictor output arrives as per-slot taken flags plus one target.

Top module: `fetch_status_ctrl`

## Requirements
- R1: After reset, the status is idle (code 0), the PC equals RESET_PC, the credit pool holds NUM_PREGS, the drop counter is 0 and no slot is strobed. A line request is raised straight away.
- R2: A line request carries the PC with its low log2(LINE_BYTES) bits cleared. The word offset output is PC bits [log2(LINE_BYTES)-1:2].
- R3: A request answered with a hit strobes slots in that same cycle. Slots are strobed from slot 0 upward with no gap, at most FETCH_W of them and at most the free-buffer count. The PC advances by 4 for each strobed slot.
- R4: A strobed slot that is predicted taken ends the cycle's strobes, and the PC becomes the predicted target.
- R5: When the next PC lies outside the current line, strobing stops and the next cycle raises a line request.
- R6: A miss sets status miss-stall (2) with no strobes. A completion whose tag matches the outstanding request moves to miss-complete (3) for one cycle with no strobes. The next status is then chosen in this order: running (1), overridden by serialize-blocked if a barrier is held, then by rename-blocked if the pool is at or below zero, then by backend-blocked if the back end blocks and the status is still running.
- R7: A completion is dropped, and the drop counter increments, when its tag does not match, when the status is not miss-stall, or when it arrives together with a squash.
- R8: Each strobed slot removes its destination count from the pool. If the pool reaches zero or below, the cycle stops and the status becomes rename-blocked (4). Returned credits add to the pool, saturating at NUM_PREGS. Rename-blocked returns to running only when the pool plus the returned credits is above zero, and the cycle that makes this decision strobes nothing.
- R9: A slot flagged serialize-before is not strobed. The status becomes serialize-blocked (5) until the back end reports idle, then serialize-complete (6). In that next cycle slot 0 is strobed even if flagged, and the status returns to running. A slot flagged serialize-after is strobed and ends the cycle; the next slot is then treated as serialize-before.
- R10: A fault raised with a line request pulses the fault-inject output and strobes nothing. The status becomes trap-pending (7), which only a squash leaves.
- R11: While the back end blocks and decoupled mode is off, a cycle that would end idle or running ends backend-blocked (8); that cycle's strobes still happen. Release goes to running, or to serialize-blocked if a barrier is held. In decoupled mode the blocking input has no effect.
- R12: A slot flagged quiesce is strobed, ends the cycle and sets quiesce-pending (9). The status stays there until wake, which returns it to running.
- R13: A squash strobes nothing that cycle. It loads the PC with the redirect, sets the status to running, drops any held barrier and cancels an outstanding miss. The following cycle raises a line request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| squash_i | input | 1 | redirect fetch |
| redirect_i | input | PC_W | redirect PC |
| line_req_o | output | 1 | line request this cycle |
| line_addr_o | output | PC_W | aligned line address |
| req_tag_o | output | TAG_W | tag of the request |
| ic_hit_i | input | 1 | request hits (valid with request) |
| fetch_fault_i | input | 1 | request faults (valid with request) |
| ic_done_i | input | 1 | miss completion |
| done_tag_i | input | TAG_W | tag of the completion |
| buf_free_i | input | BUF_W | free instruction-buffer entries |
| slot_dst_i | input | FETCH_W*DST_W | destination count per slot |
| slot_taken_i | input | FETCH_W | slot predicted taken |
| slot_sbefore_i | input | FETCH_W | slot serializes before itself |
| slot_safter_i | input | FETCH_W | slot serializes after itself |
| slot_quiesce_i | input | FETCH_W | slot is a quiesce |
| pred_target_i | input | PC_W | target of the taken slot |
| credit_i | input | CREDIT_W | returned rename credits |
| ser_busy_i | input | 1 | back end not yet drained |
| be_blocked_i | input | 1 | back end blocked |
| decoupled_i | input | 1 | ignore back-end blocking |
| wake_i | input | 1 | leave quiesce-pending |
| pc_o | output | PC_W | fetch PC |
| line_off_o | output | LINE_OFF_W-2 | word offset of PC within line |
| slot_valid_o | output | FETCH_W | strobed slots |
| fault_inj_o | output | 1 | fault-carrying no-op injected |
| status_o | output | 4 | status code |
| free_regs_o | output | FS | signed rename credit pool |
| drops_o | output | 8 | dropped completions |

## Verification
The strobe logic is driven from a table. The rows vary the start word within the line, the free-buffer count and the taken flags. Rows with no stop condition, a buffer limit, a taken flag in the middle and a line crossing each end the cycle for a different reason, and the resulting strobe mask and next PC show which stop applied. Directed sequences then take the controller through each status in turn: matched and stale completions, credit exhaustion with a return that is too small and then one that is large enough, barriers before and after, fault, back-end block with and without decoupling, and quiesce. Each sequence checks both the strobe pattern and the status code on the cycle it is expected to change.

// File: rtl/fetch_status_ctrl.sv
module fetch_status_ctrl #(
  parameter int PC_W = 32,
  parameter int LINE_BYTES = 64,
  parameter int FETCH_W = 4,
  parameter int BUF_W = 4,
  parameter int DST_W = 2,
  parameter int NUM_PREGS = 32,
  parameter int CREDIT_W = 6,
  parameter int TAG_W = 4,
  parameter logic [PC_W-1:0] RESET_PC = 32'h1000,
  localparam int LINE_OFF_W = $clog2(LINE_BYTES),
  localparam int FR_W = $clog2(NUM_PREGS + 1),
  localparam int FS = ((FR_W > CREDIT_W) ? FR_W : CREDIT_W) + 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     squash_i,
  input  logic [PC_W-1:0]          redirect_i,
  output logic                     line_req_o,
  output logic [PC_W-1:0]          line_addr_o,
  output logic [TAG_W-1:0]         req_tag_o,
  input  logic                     ic_hit_i,
  input  logic                     fetch_fault_i,
  input  logic                     ic_done_i,
  input  logic [TAG_W-1:0]         done_tag_i,
  input  logic [BUF_W-1:0]         buf_free_i,
  input  logic [FETCH_W*DST_W-1:0] slot_dst_i,
  input  logic [FETCH_W-1:0]       slot_taken_i,
  input  logic [FETCH_W-1:0]       slot_sbefore_i,
  input  logic [FETCH_W-1:0]       slot_safter_i,
  input  logic [FETCH_W-1:0]       slot_quiesce_i,
  input  logic [PC_W-1:0]          pred_target_i,
  input  logic [CREDIT_W-1:0]      credit_i,
  input  logic                     ser_busy_i,
  input  logic                     be_blocked_i,
  input  logic                     decoupled_i,
  input  logic                     wake_i,
  output logic [PC_W-1:0]          pc_o,
  output logic [LINE_OFF_W-3:0]    line_off_o,
  output logic [FETCH_W-1:0]       slot_valid_o,
  output logic                     fault_inj_o,
  output logic [3:0]               status_o,
  output logic signed [FS-1:0]     free_regs_o,
  output logic [7:0]               drops_o
);

  typedef enum logic [3:0] {
    S_IDLE = 4'd0, S_RUN = 4'd1, S_MSTALL = 4'd2, S_MDONE = 4'd3, S_RBLK = 4'd4,
    S_SBLK = 4'd5, S_SDONE = 4'd6, S_TRAP = 4'd7, S_BBLK = 4'd8, S_QPEND = 4'd9
  } st_t;

  st_t st, st_n;
  logic [PC_W-1:0] pc, pc_n, lbase, lbase_n;
  logic lv, lv_n, fln, fln_n, bar, bar_n, sn, sn_n;
  logic [TAG_W-1:0] tag, tag_n;
  logic signed [FS-1:0] free, fr, sum, free_n;
  logic [7:0] drops;
  logic done_ok, be_blk;

  function automatic logic [PC_W-1:0] align(input logic [PC_W-1:0] a);
    return {a[PC_W-1:LINE_OFF_W], {LINE_OFF_W{1'b0}}};
  endfunction

  assign be_blk  = be_blocked_i & ~decoupled_i;
  assign done_ok = ic_done_i && (done_tag_i == tag) && (st == S_MSTALL) && !squash_i;

  always_comb begin
    logic go, stop;
    logic [PC_W-1:0] cpc;
    st_n = st; pc_n = pc; lbase_n = lbase; lv_n = lv; fln_n = fln;
    bar_n = bar; sn_n = sn; tag_n = tag; fr = free;
    line_req_o = 1'b0; slot_valid_o = '0; fault_inj_o = 1'b0;
    go = 1'b0; stop = 1'b0; cpc = pc;
    if (squash_i) begin
      pc_n = redirect_i; st_n = S_RUN; fln_n = 1'b1; bar_n = 1'b0;
    end else begin
      case (st)
        S_MSTALL: if (done_ok) st_n = S_MDONE;
        S_MDONE: begin
          lv_n = 1'b1;
          st_n = S_RUN;
          if (bar) st_n = S_SBLK;
          if (free <= 0) st_n = S_RBLK;
          if (be_blk && st_n == S_RUN) st_n = S_BBLK;
        end
        S_SBLK:  if (!ser_busy_i) st_n = S_SDONE;
        S_BBLK:  if (!be_blk) st_n = bar ? S_SBLK : S_RUN;
        S_RBLK:  if (free + $signed(FS'(credit_i)) > 0) st_n = S_RUN;
        S_QPEND: if (wake_i) st_n = S_RUN;
        S_TRAP:  ;
        default: begin
          go = 1'b1;
          if (fln) begin
            line_req_o = 1'b1;
            tag_n = tag + 1'b1;
            if (fetch_fault_i) begin
              st_n = S_TRAP; fault_inj_o = 1'b1; go = 1'b0;
            end else begin
              lbase_n = align(pc); fln_n = 1'b0; lv_n = ic_hit_i;
              if (!ic_hit_i) begin st_n = S_MSTALL; go = 1'b0; end
            end
          end
          if (go) begin
            if (st == S_SDONE) begin st_n = S_RUN; bar_n = 1'b0; end
            for (int i = 0; i < FETCH_W; i++) begin
              if (!stop) begin
                if (i >= int'(buf_free_i)) stop = 1'b1;
                else if (!lv_n || align(cpc) != lbase_n) begin
                  fln_n = 1'b1; stop = 1'b1;
                end else if (sn_n || (slot_sbefore_i[i] && !(i == 0 && st == S_SDONE))) begin
                  sn_n = 1'b0; st_n = S_SBLK; bar_n = 1'b1; stop = 1'b1;
                end else begin
                  if (slot_safter_i[i]) sn_n = 1'b1;
                  slot_valid_o[i] = 1'b1;
                  fr = fr - $signed(FS'(slot_dst_i[i*DST_W +: DST_W]));
                  cpc = slot_taken_i[i] ? pred_target_i : cpc + 4;
                  if (slot_quiesce_i[i]) begin st_n = S_QPEND; stop = 1'b1; end
                  else if (slot_taken_i[i]) stop = 1'b1;
                  else if (fr <= 0) begin st_n = S_RBLK; stop = 1'b1; end
                  else if (sn_n) stop = 1'b1;
                end
              end
            end
            pc_n = cpc;
            if (be_blk && (st_n == S_RUN || st_n == S_IDLE)) st_n = S_BBLK;
          end
        end
      endcase
    end
    sum = fr + $signed(FS'(credit_i));
    free_n = (sum > $signed(FS'(NUM_PREGS))) ? $signed(FS'(NUM_PREGS)) : sum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; pc <= RESET_PC; lbase <= '0; lv <= 1'b0; fln <= 1'b1;
      bar <= 1'b0; sn <= 1'b0; tag <= '0; free <= FS'(NUM_PREGS); drops <= '0;
    end else begin
      st <= st_n; pc <= pc_n; lbase <= lbase_n; lv <= lv_n; fln <= fln_n;
      bar <= bar_n; sn <= sn_n; tag <= tag_n; free <= free_n;
      if (ic_done_i && !done_ok) drops <= drops + 1'b1;
    end
  end

  assign line_addr_o = align(pc);
  assign req_tag_o   = tag + 1'b1;
  assign pc_o        = pc;
  assign line_off_o  = pc[LINE_OFF_W-1:2];
  assign status_o    = st;
  assign free_regs_o = free;
  assign drops_o     = drops;

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_MSTALL && !ic_done_i && !squash_i) |=> (st == S_MSTALL));

  // R8
  pool_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    free <= $signed(FS'(NUM_PREGS)));

  // R8
  rename_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RBLK && !squash_i && (free + $signed(FS'(credit_i)) <= 0)) |=> (st == S_RBLK));

  // R13
  squash_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    squash_i |=> (pc == $past(redirect_i)) && (st == S_RUN) && fln);

  // R10
  trap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_TRAP) |-> (slot_valid_o == '0) && !line_req_o);

  // R3
  strobe_prefix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (((slot_valid_o + 1'b1) & slot_valid_o) == '0));

endmodule

// File: tb/fetch_status_ctrl_test.sv
module fetch_status_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int FW = 4;

  logic clk = 0, rst_n = 0;
  logic squash_i = 0, ic_hit_i = 1, fetch_fault_i = 0, ic_done_i = 0;
  logic [31:0] redirect_i = 0, pred_target_i = 32'h2000;
  logic [3:0] done_tag_i = 0, buf_free_i = 0;
  logic [7:0] slot_dst_i = 0;
  logic [3:0] slot_taken_i = 0, slot_sbefore_i = 0, slot_safter_i = 0, slot_quiesce_i = 0;
  logic [5:0] credit_i = 0;
  logic ser_busy_i = 0, be_blocked_i = 0, decoupled_i = 0, wake_i = 0;
  logic line_req_o, fault_inj_o;
  logic [31:0] line_addr_o, pc_o;
  logic [3:0] req_tag_o, slot_valid_o, status_o, line_off_o;
  logic signed [7:0] free_regs_o;
  logic [7:0] drops_o;

  int checks = 0, errors = 0;
  logic [3:0] tag_hold;
  int drops_base;

  fetch_status_ctrl uut (
    .clk, .rst_n, .squash_i, .redirect_i, .line_req_o, .line_addr_o, .req_tag_o,
    .ic_hit_i, .fetch_fault_i, .ic_done_i, .done_tag_i, .buf_free_i, .slot_dst_i,
    .slot_taken_i, .slot_sbefore_i, .slot_safter_i, .slot_quiesce_i, .pred_target_i,
    .credit_i, .ser_busy_i, .be_blocked_i, .decoupled_i, .wake_i, .pc_o, .line_off_o,
    .slot_valid_o, .fault_inj_o, .status_o, .free_regs_o, .drops_o
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  localparam int NT = 6;
  localparam logic [31:0] T_PC   [NT] = '{32'h1000, 32'h1000, 32'h1004, 32'h1038, 32'h103C, 32'h1000};
  localparam logic [3:0]  T_BUF  [NT] = '{4'd8, 4'd2, 4'd8, 4'd8, 4'd8, 4'd0};
  localparam logic [3:0]  T_TKN  [NT] = '{4'b0000, 4'b0000, 4'b0010, 4'b0000, 4'b0001, 4'b0000};
  localparam logic [3:0]  T_VLD  [NT] = '{4'b1111, 4'b0011, 4'b0011, 4'b0011, 4'b0001, 4'b0000};
  localparam logic [31:0] T_NPC  [NT] = '{32'h1010, 32'h1008, 32'h2000, 32'h1040, 32'h2000, 32'h1000};

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic do_squash(input logic [31:0] a);
    squash_i = 1; redirect_i = a;
    #1 chk("R13 no strobe on squash", slot_valid_o, 0);
    tick();
    squash_i = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    finish_run();
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1 status", status_o, 0);
    chk("R1 pc", pc_o, 32'h1000);
    chk("R1 pool", free_regs_o, 32);
    chk("R1 drops", drops_o, 0);
    chk("R1 no strobe", slot_valid_o, 0);
    chk("R1 request", line_req_o, 1);
    tick();

    for (int k = 0; k < NT; k++) begin
      do_squash(T_PC[k]);
      buf_free_i = T_BUF[k]; slot_taken_i = T_TKN[k];
      #1;
      chk("R13 request after squash", line_req_o, 1);
      chk("R2 line addr", line_addr_o, T_PC[k] & 32'hFFFF_FFC0);
      chk("R2 word offset", line_off_o, (T_PC[k] >> 2) & 4'hF);
      chk("R3 R4 R5 strobes", slot_valid_o, T_VLD[k]);
      tick();
      slot_taken_i = 0;
      chk("R3 R4 R5 next pc", pc_o, T_NPC[k]);
      if (k == 3) begin
        buf_free_i = 8; #1;
        chk("R5 new line request", line_req_o, 1);
        chk("R5 new line addr", line_addr_o, 32'h1040);
      end
    end

    // R6 miss path and R7 stale completion
    do_squash(32'h1000);
    ic_hit_i = 0; buf_free_i = 8;
    #1 chk("R6 strobe on miss", slot_valid_o, 0);
    tag_hold = req_tag_o;
    drops_base = drops_o;
    tick();
    ic_hit_i = 1;
    chk("R6 stall", status_o, 2);
    tick();
    chk("R6 stall holds", status_o, 2);
    ic_done_i = 1; done_tag_i = tag_hold + 4'd1;
    tick();
    chk("R7 tag mismatch dropped", drops_o, drops_base + 1);
    chk("R7 still stalled", status_o, 2);
    done_tag_i = tag_hold;
    tick();
    ic_done_i = 0;
    chk("R6 complete", status_o, 3);
    #1 chk("R6 no strobe on complete", slot_valid_o, 0);
    tick();
    chk("R6 resolves running", status_o, 1);
    #1;
    chk("R6 no re-request", line_req_o, 0);
    chk("R6 strobes after miss", slot_valid_o, 4'b1111);
    do_squash(32'h1000);
    ic_hit_i = 0;
    tag_hold = req_tag_o;
    tick();
    ic_hit_i = 1;
    drops_base = drops_o;
    do_squash(32'h1000);
    ic_done_i = 1; done_tag_i = tag_hold;
    tick();
    ic_done_i = 0;
    chk("R7 R13 cancelled miss dropped", drops_o, drops_base + 1);

    // R8 rename credits
    do_squash(32'h1000);
    slot_dst_i = 8'hFF; buf_free_i = 8;
    tick();
    chk("R8 pool after 4x3", free_regs_o, 20);
    tick();
    chk("R8 pool after 8x3", free_regs_o, 8);
    #1 chk("R8 stop at exhaustion", slot_valid_o, 4'b0111);
    tick();
    slot_dst_i = 0;
    chk("R8 rename blocked", status_o, 4);
    chk("R8 pool negative", free_regs_o, -1);
    credit_i = 1;
    #1 chk("R8 bubble no strobe", slot_valid_o, 0);
    tick();
    chk("R8 total zero stays", status_o, 4);
    credit_i = 5;
    tick();
    credit_i = 0;
    chk("R8 leaves block", status_o, 1);
    chk("R8 pool after credit", free_regs_o, 5);
    buf_free_i = 0; credit_i = 40;
    tick();
    credit_i = 0;
    chk("R8 saturation", free_regs_o, 32);

    // R9 serialize before / after
    do_squash(32'h1000);
    buf_free_i = 8; slot_sbefore_i = 4'b0100;
    #1 chk("R9 barrier not strobed", slot_valid_o, 4'b0011);
    ser_busy_i = 1;
    tick();
    chk("R9 serialize blocked", status_o, 5);
    tick();
    chk("R9 waits for drain", status_o, 5);
    ser_busy_i = 0;
    tick();
    chk("R9 serialize complete", status_o, 6);
    slot_sbefore_i = 4'b0001;
    #1 chk("R9 barrier reissued", slot_valid_o, 4'b1111);
    tick();
    slot_sbefore_i = 0;
    chk("R9 back to running", status_o, 1);
    do_squash(32'h1000);
    slot_safter_i = 4'b0010;
    #1 chk("R9 after-barrier strobed", slot_valid_o, 4'b0011);
    tick();
    slot_safter_i = 0;
    #1 chk("R9 next slot blocked", slot_valid_o, 0);
    tick();
    chk("R9 after-barrier blocks", status_o, 5);

    // R10 fault
    do_squash(32'h1000);
    fetch_fault_i = 1;
    #1;
    chk("R10 fault inject", fault_inj_o, 1);
    chk("R10 no strobe", slot_valid_o, 0);
    tick();
    fetch_fault_i = 0;
    chk("R10 trap", status_o, 7);
    tick();
    chk("R10 trap holds", status_o, 7);

    // R11 backend blocking
    do_squash(32'h1000);
    be_blocked_i = 1;
    #1 chk("R11 strobes before block", slot_valid_o, 4'b1111);
    tick();
    chk("R11 backend blocked", status_o, 8);
    #1 chk("R11 no strobe while blocked", slot_valid_o, 0);
    be_blocked_i = 0;
    tick();
    chk("R11 release", status_o, 1);
    do_squash(32'h1000);
    be_blocked_i = 1; decoupled_i = 1;
    tick();
    chk("R11 decoupled ignores", status_o, 1);
    be_blocked_i = 0; decoupled_i = 0;

    // R12 quiesce
    do_squash(32'h1000);
    slot_quiesce_i = 4'b0010;
    #1 chk("R12 quiesce strobes", slot_valid_o, 4'b0011);
    tick();
    slot_quiesce_i = 0;
    chk("R12 quiesce pending", status_o, 9);
    tick();
    chk("R12 holds", status_o, 9);
    wake_i = 1;
    tick();
    wake_i = 0;
    chk("R12 wake", status_o, 1);

    finish_run();
  end
endmodule